// File: doc/BRIEF.md
# Ring-Sampled Random Word Generator

This block is a memory-mapped random number source with a 32-bit register port. Software programs a sampling period, then writes a control word that enables the generator, chooses one of four raw entropy rings and asks for 64, 128, 192 or 256 bits. While the run is active, the block takes one raw bit from the chosen ring each time its sample timer expires. Each bit goes into an output bank of eight 32-bit words. When the requested number of bits has been gathered, the hardware clears the start bit, and software, which polls that bit, then reads the words.

The raw ring bits arrive on a 4-bit input, one bit per ring. They pass through a parameterised synchronizer before they are sampled. Writing a control word with the start bit clear stops a run at once. A run that has ended keeps its words until the next start, which wipes the whole bank first.

Top module: `osc_rng_core`

## Requirements
- R1: After reset the control register reads 0, the sample-period register reads 100 and every output word reads 0.
- R2: The control register is at offset 0x400. Bit 0 is start, bit 1 is enable, bits 3:2 select the ring and bits 5:4 select the length. These fields read back as written, and all other bits read 0.
- R3: The sample-period register is at offset 0x404 and holds 16 bits. During a run, raw bit k (counted from 0) is taken at the (k+1)*P-th rising clock edge after the edge that accepted the start write. P is the programmed period, and a period of 0 acts as 1.
- R4: The sampled bit is input ring_raw[sel], where sel is control bits 3:2.
- R5: Length code L in bits 5:4 asks for 64*(L+1) bits. The start bit clears at the edge that stores the last bit, 64*(L+1)*P edges after the start write.
- R6: Bit k is stored in output word k/32 at bit position k%32. Output word i reads at offset 0x410+4*i, for i from 0 to 7.
- R7: An output word whose index is 2*(L+1) or more reads 0 under the current length code L, and the stored value reappears when L is raised again without a start. A write that sets start clears all eight words.
- R8: A control write with start=1 but enable=0 does not set start and leaves the output words unchanged.
- R9: A control write with bits 15:0 equal to zero during a run clears start, and no further bits are stored.
- R10: Each ring bit passes through SYNC_STAGES flip-flops (default 2) before it is sampled. The bit stored at an edge is therefore the ring value from SYNC_STAGES edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ring_raw | input | 4 | Raw entropy bits, one per ring |

## Verification
The bench drives each ring input with a hashed function of the cycle number, so that every ring carries a different and fast-changing sequence. Every collected word then shows which ring was picked, the exact sample edges and the bit order. Four runs are made, each with a different length, ring and period (one of them a period of zero). These runs tell apart an off-by-one in the period, a wrong synchronizer depth and word-order mistakes. After the runs, the length field is lowered and raised again without a start, and this separates read masking from bank clearing. A start attempt without enable and an abort in mid-run show whether start can slip past the enable gate and whether sampling keeps going after a stop.

// File: rtl/osc_rng_pkg.sv
package osc_rng_pkg;
   localparam int unsigned CTRL_OFS = 32'h400;
   localparam int unsigned PER_OFS  = 32'h404;
   localparam int unsigned DATA_OFS = 32'h410;

   typedef struct packed {
      logic [1:0] len;
      logic [1:0] ring;
      logic       en;
      logic       start;
   } ctrl_t;
endpackage

// File: rtl/rng_ring_sync.sv
module rng_ring_sync #(
   parameter int NUM_RINGS   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_RINGS-1:0] raw_in,
   output logic [NUM_RINGS-1:0] sync_out
);
   generate
      if (SYNC_STAGES == 0) begin : g_bypass
         assign sync_out = raw_in;
      end else begin : g_chain
         logic [NUM_RINGS-1:0] st_q [SYNC_STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) st_q[i] <= '0;
            end else begin
               st_q[0] <= raw_in;
               for (int i = 1; i < SYNC_STAGES; i++) st_q[i] <= st_q[i-1];
            end
         end
         assign sync_out = st_q[SYNC_STAGES-1];

         for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_chk
            // R10: each stage carries the previous stage one edge later
            assert_stage_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
               $past(rst_n) |-> st_q[s] == $past(st_q[s-1]));
         end
      end
   endgenerate
endmodule

// File: rtl/rng_sample_timer.sv
module rng_sample_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [CNT_W-1:0] period,
   output logic             tick
);
   logic [CNT_W-1:0] cnt_q;
   logic             hit;

   assign hit  = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, period};
   assign tick = run && hit && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clr)      cnt_q <= '0;
      else if (run) begin
         if (hit)        cnt_q <= '0;
         else            cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // R3: between samples the counter advances by exactly one per clock
   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr && !tick) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
   // R3: a sample restarts the period count
   assert_tick_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> cnt_q == '0);
endmodule

// File: rtl/rng_bit_bank.sv
module rng_bit_bank #(
   parameter int WORDS  = 8,
   parameter int WORD_W = 32,
   localparam int BANK_BITS = WORDS * WORD_W,
   localparam int BIT_W     = $clog2(BANK_BITS),
   localparam int WIDX_W    = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift,
   input  logic [BIT_W-1:0]  wr_bit,
   input  logic              din,
   input  logic [WIDX_W-1:0] rd_idx,
   output logic [WORD_W-1:0] rd_word
);
   logic [BANK_BITS-1:0] bits_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      bits_q <= '0;
      else if (clr)    bits_q <= '0;
      else if (shift)  bits_q[wr_bit] <= din;
   end

   assign rd_word = bits_q[rd_idx*WORD_W +: WORD_W];

   // R7: a start wipes every word
   assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> bits_q == '0);
   // R9: with no sample pending the bank holds its contents
   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !shift) |=> $stable(bits_q));
endmodule

// File: rtl/osc_rng_core.sv
module osc_rng_core
   import osc_rng_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int WORD_W      = 32,
   parameter int WORDS       = 8,
   parameter int NUM_RINGS   = 4,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 16,
   parameter int RST_PERIOD  = 100
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [WORD_W-1:0]    reg_wdata,
   output logic [WORD_W-1:0]    reg_rdata,
   input  logic [NUM_RINGS-1:0] ring_raw
);
   localparam int BANK_BITS = WORDS * WORD_W;
   localparam int BIT_W     = $clog2(BANK_BITS);
   localparam int WIDX_W    = $clog2(WORDS);
   localparam int QUARTER   = BANK_BITS / 4;

   initial begin
      assert (WORD_W == 32) else $error("register port must be 32 bits wide");
      assert (WORDS % 4 == 0) else $error("WORDS must split into four length steps");
      assert (NUM_RINGS == 4) else $error("ring select field is two bits wide");
      assert (CNT_W <= WORD_W) else $error("period register wider than port");
   end

   ctrl_t                 ctrl_q;
   logic [CNT_W-1:0]      per_q;
   logic [BIT_W-1:0]      bit_cnt_q;
   logic [BIT_W-1:0]      last_bit;
   logic [NUM_RINGS-1:0]  ring_s;
   logic                  ctrl_wr, per_wr, start_req, shift, done;
   logic                  in_data, word_live;
   logic [ADDR_W-1:0]     data_off;
   logic [WIDX_W-1:0]     rd_idx;
   logic [WORD_W-1:0]     bank_word;

   assign ctrl_wr   = reg_wr && (reg_addr == ADDR_W'(CTRL_OFS));
   assign per_wr    = reg_wr && (reg_addr == ADDR_W'(PER_OFS));
   assign start_req = ctrl_wr && reg_wdata[0] && reg_wdata[1];
   assign last_bit  = BIT_W'((32'(ctrl_q.len) + 32'd1) * QUARTER - 1);
   assign done      = shift && (bit_cnt_q == last_bit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         per_q  <= CNT_W'(RST_PERIOD);
      end else begin
         if (ctrl_wr) begin
            ctrl_q.len   <= reg_wdata[5:4];
            ctrl_q.ring  <= reg_wdata[3:2];
            ctrl_q.en    <= reg_wdata[1];
            ctrl_q.start <= start_req;
         end else if (done) begin
            ctrl_q.start <= 1'b0;
         end
         if (per_wr) per_q <= reg_wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         bit_cnt_q <= '0;
      else if (start_req) bit_cnt_q <= '0;
      else if (shift)     bit_cnt_q <= bit_cnt_q + BIT_W'(1);
   end

   rng_ring_sync #(.NUM_RINGS(NUM_RINGS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw_in(ring_raw), .sync_out(ring_s));

   rng_sample_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(ctrl_wr), .run(ctrl_q.start),
      .period(per_q), .tick(shift));

   assign data_off  = reg_addr - ADDR_W'(DATA_OFS);
   assign in_data   = (reg_addr >= ADDR_W'(DATA_OFS)) &&
                      (reg_addr <  ADDR_W'(DATA_OFS + 4 * WORDS)) &&
                      (reg_addr[1:0] == 2'b00);
   assign rd_idx    = WIDX_W'(data_off >> 2);
   assign word_live = 32'(rd_idx) < (32'(ctrl_q.len) + 32'd1) * (WORDS / 4);

   rng_bit_bank #(.WORDS(WORDS), .WORD_W(WORD_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .clr(start_req), .shift(shift),
      .wr_bit(bit_cnt_q), .din(ring_s[ctrl_q.ring]),
      .rd_idx(rd_idx), .rd_word(bank_word));

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(CTRL_OFS))     reg_rdata = WORD_W'(ctrl_q);
      else if (reg_addr == ADDR_W'(PER_OFS)) reg_rdata = WORD_W'(per_q);
      else if (in_data && word_live)         reg_rdata = bank_word;
   end

   // R8: start can only rise from a control write that also sets enable
   assert_start_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_q.start) |-> $past(ctrl_wr && reg_wdata[1]));
   // R5: start drops by itself only at an edge that stored a bit
   assert_done_on_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctrl_q.start) && !$past(ctrl_wr)) |-> $past(shift));
   // R9: no sampling while start is clear
   assert_idle_no_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.start |-> !shift);
endmodule

// File: tb/osc_rng_core_test.sv
module osc_rng_core_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = 12'h0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic [3:0]  ring_raw = 4'h0;

   int          cyc = 0;
   int          checks = 0;
   int          failures = 0;
   bit          finished = 1'b0;
   bit          mon_req = 1'b0;
   logic [31:0] exp_q [$];
   logic [31:0] last_words [8];

   localparam int SYNC = 2;

   osc_rng_core uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ring_raw(ring_raw));

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [3:0] pat(input int c);
      logic [31:0] h;
      h = 32'(c) * 32'h9E3779B1;
      return h[31:28] ^ h[19:16];
   endfunction

   always @(negedge clk) ring_raw = pat(cyc);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // driver: program, push expected words, start, time the completion
   task automatic run_gen(input int len, input int ring, input int per, input string req);
      int          pe, nbits, c0, bitpos;
      logic [31:0] w [8];
      logic [31:0] d;
      pe    = (per == 0) ? 1 : per;
      nbits = 64 * (len + 1);
      wr(12'h404, 32'(per));
      @(negedge clk);
      c0 = cyc;
      reg_wr = 1'b1; reg_addr = 12'h400;
      reg_wdata = 32'((len << 4) | (ring << 2) | 3);
      for (int i = 0; i < 8; i++) w[i] = 32'h0;
      for (int k = 0; k < nbits; k++) begin
         bitpos = c0 + (k + 1) * pe - SYNC;
         w[k / 32][k % 32] = pat(bitpos)[ring];
      end
      for (int i = 0; i < 8; i++) begin
         exp_q.push_back(w[i]);
         last_words[i] = w[i];
      end
      @(negedge clk);
      reg_wr = 1'b0;
      reg_addr = 12'h400;
      #1 d = reg_rdata;
      while (d[0] === 1'b1) begin
         @(negedge clk);
         #1 d = reg_rdata;
      end
      check({req, " R5 completion edge count"}, 32'(cyc - c0), 32'(nbits * pe + 1));
      mon_req = 1'b1;
      wait (mon_req == 1'b0);
   endtask

   // monitor: pop the expected words and compare with the bank
   initial begin
      logic [31:0] d, e;
      forever begin
         wait (mon_req == 1'b1);
         for (int i = 0; i < 8; i++) begin
            rd(12'(12'h410 + 4 * i), d);
            e = exp_q.pop_front();
            check($sformatf("R4 R6 R10 word %0d", i), d, e);
         end
         mon_req = 1'b0;
      end
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, keep;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(12'h400, d); check("R1 ctrl reset", d, 32'h0);
      rd(12'h404, d); check("R1 period reset", d, 32'd100);
      rd(12'h410, d); check("R1 word0 reset", d, 32'h0);
      rd(12'h42C, d); check("R1 word7 reset", d, 32'h0);
      // R2 field readback, other bits zero
      wr(12'h400, 32'hFFFF_FFFE); rd(12'h400, d); check("R2 ctrl readback", d, 32'h3E);
      wr(12'h400, 32'h0000_0016); rd(12'h400, d); check("R2 ctrl fields", d, 32'h16);
      wr(12'h404, 32'h0001_0005); rd(12'h404, d); check("R3 period readback", d, 32'd5);
      // full-length run
      run_gen(3, 1, 4, "runA");
      // R7 masking by current length, no clearing
      wr(12'h400, 32'h02);
      rd(12'h410, d); check("R7 live word0", d, last_words[0]);
      rd(12'h418, d); check("R7 masked word2", d, 32'h0);
      rd(12'h42C, d); check("R7 masked word7", d, 32'h0);
      wr(12'h400, 32'h32);
      rd(12'h42C, d); check("R7 word7 reappears", d, last_words[7]);
      // R8 start without enable
      wr(12'h400, 32'h3D);
      rd(12'h400, d); check("R8 start not set", d, 32'h3C);
      repeat (10) @(negedge clk);
      rd(12'h410, d); check("R8 word0 kept", d, last_words[0]);
      wr(12'h400, 32'h32);
      rd(12'h424, d); check("R8 word5 kept", d, last_words[5]);
      // R3 period zero acts as one
      run_gen(0, 0, 0, "runB");
      wr(12'h400, 32'h32);
      rd(12'h418, d); check("R7 cleared word2", d, 32'h0);
      rd(12'h42C, d); check("R7 cleared word7", d, 32'h0);
      run_gen(2, 2, 5, "runC");
      run_gen(1, 3, 3, "runD");
      // R9 abort mid-run
      wr(12'h404, 32'd2);
      wr(12'h400, 32'h33);
      repeat (20) @(negedge clk);
      wr(12'h400, 32'h0);
      rd(12'h400, d); check("R9 ctrl after stop", d, 32'h0);
      wr(12'h400, 32'h30);
      rd(12'h410, keep);
      repeat (30) @(negedge clk);
      rd(12'h410, d); check("R9 word0 stable", d, keep);
      rd(12'h414, d);
      rd(12'h400, d); check("R9 start stays low", d, 32'h30);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule